// File: doc/BRIEF.md
# Byte-Loaded Test-Clock Down Counter

This block sets how many test-clock cycles a scan or self-test operation lasts. A host with an 8-bit data path fills the 32-bit count through one write port with four back-to-back byte writes. The lowest byte goes first. Once the last byte lands, the counter is marked loaded. From then on it steps down by one on every cycle in which the clock gate reports an issued test-clock pulse. It stops at zero and does not wrap.

The block tells the clock gate when to stall: when it is enabled and either not loaded or at zero. It raises a level interrupt request for the same conditions when interrupts are enabled. When automatic force-high is enabled, it asks for the mode-select line to be driven high while the count equals one, which is the final cycle of the run. A small three-bit mode register holds the enables. After reset only the count enable is set.

Top module: `tckcnt_top`

## Requirements
- R1: After reset the count is 0 and the loaded flag is 0. The mode register resets to count enable only (mode bit0=1, bit1=0, bit2=0). So stall_o=1, irq_o=0 and ms_high_o=0.
- R2: Four writes on ld_wr load the count least significant byte first. The first byte is bits 7:0 and the fourth is bits 31:24. The new count and loaded_o=1 appear in the cycle after the fourth write.
- R3: The first byte write of a new load clears loaded_o from the next cycle. count_o keeps its old value until the fourth byte. A byte write takes precedence over a same-cycle tck_fire, which then has no effect on the count.
- R4: count_o falls by exactly one in the cycle after each cycle with tck_fire=1, but only while count enable (mode bit0) is 1, the counter is loaded and the count is nonzero. Otherwise the count is unchanged.
- R5: At a count of 0, term_o=1 and the count stays 0 under further tck_fire pulses.
- R6: stall_o = count enable AND (NOT loaded OR count==0).
- R7: irq_o = interrupt enable (mode bit2) AND (NOT loaded OR count==0). This does not depend on the count enable.
- R8: ms_high_o = force-high enable (mode bit1) AND loaded AND count==1.
- R9: last_o is 1 exactly when the count equals 1.
- R10: The byte pointer wraps after the fourth write. A fifth write starts a new load and clears loaded_o.
- R11: mode_wr loads mode_din into the mode register. Bit0 is count enable, bit1 is force-high enable and bit2 is interrupt enable. The new setting acts from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_din | input | 3 | Mode value: bit0 count enable, bit1 force-high enable, bit2 interrupt enable |
| ld_wr | input | 1 | Byte write strobe for the counter address |
| ld_byte | input | 8 | Byte being written |
| tck_fire | input | 1 | Clock gate issued a test-clock pulse this cycle |
| count_o | output | 32 | Current count |
| loaded_o | output | 1 | All four bytes of the current load have arrived |
| term_o | output | 1 | Count is zero |
| last_o | output | 1 | Count is one |
| stall_o | output | 1 | Request to stop the test clock |
| irq_o | output | 1 | Level interrupt request |
| ms_high_o | output | 1 | Request to force mode-select high |

## Verification
Two events can fall in one cycle. The first byte of a reload can meet a test-clock pulse. A mode write can also meet a pulse. The bench drives a byte write and tck_fire in the same cycle while the counter is loaded and nonzero. It then checks that loaded_o drops and that count_o keeps its value, with no decrement. It also disables counting with a mode write in the cycle of a pulse. There the old enable decides that pulse, and only later pulses see the new one. A behavioural reference model is compared on every clock, and a stretch of random stimulus mixes all of these cases.

// File: rtl/tckcnt_pkg.sv
package tckcnt_pkg;
   typedef struct packed {
      logic irq_en;
      logic auto_en;
      logic cnt_en;
   } mode_t;

   localparam mode_t MODE_RESET = '{irq_en: 1'b0, auto_en: 1'b0, cnt_en: 1'b1};

   function automatic int unsigned lanes_of(input int unsigned total_w, input int unsigned lane_w);
      return total_w / lane_w;
   endfunction
endpackage

// File: rtl/tckcnt_mode.sv
module tckcnt_mode
   import tckcnt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [2:0] din,
   output mode_t      mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mode <= MODE_RESET;
      else if (wr) mode <= mode_t'(din);
   end
endmodule

// File: rtl/tckcnt_loader.sv
module tckcnt_loader
   import tckcnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wbyte,
   output logic              commit,
   output logic [CNT_W-1:0]  load_val,
   output logic              loaded
);
   localparam int unsigned NB    = lanes_of(CNT_W, BYTE_W);
   localparam int unsigned PTR_W = (NB > 1) ? $clog2(NB) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NB - 1);

   logic [PTR_W-1:0] ptr;
   logic             start;

   assign start  = wr && (ptr == '0);
   assign commit = wr && (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (commit) ptr <= '0;
      else if (wr)     ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      loaded <= 1'b0;
      else if (commit) loaded <= 1'b1;
      else if (start)  loaded <= 1'b0;
   end

   for (genvar g = 0; g < NB - 1; g++) begin : g_lane
      logic [BYTE_W-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         stage <= '0;
         else if (wr && ptr == PTR_W'(g))    stage <= wbyte;
      end
      assign load_val[g*BYTE_W +: BYTE_W] = stage;
   end
   assign load_val[(NB-1)*BYTE_W +: BYTE_W] = wbyte;
endmodule

// File: rtl/tckcnt_flags.sv
module tckcnt_flags
   import tckcnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [CNT_W-1:0] cnt,
   output logic             is_zero,
   output logic             is_one
);
   localparam int unsigned NB = lanes_of(CNT_W, BYTE_W);

   logic [NB-1:0] lane_nz;
   for (genvar g = 0; g < NB; g++) begin : g_nz
      assign lane_nz[g] = |cnt[g*BYTE_W +: BYTE_W];
   end

   logic low_is_one;
   assign low_is_one = (cnt[BYTE_W-1:0] == BYTE_W'(1));
   assign is_zero    = ~|lane_nz;
   assign is_one     = low_is_one && ~|lane_nz[NB-1:1];
endmodule

// File: rtl/tckcnt_core.sv
module tckcnt_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (commit) cnt <= load_val;
      else if (step)   cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/tckcnt_top.sv
module tckcnt_top
   import tckcnt_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_din,
   input  logic              ld_wr,
   input  logic [BYTE_W-1:0] ld_byte,
   input  logic              tck_fire,
   output logic [CNT_W-1:0]  count_o,
   output logic              loaded_o,
   output logic              term_o,
   output logic              last_o,
   output logic              stall_o,
   output logic              irq_o,
   output logic              ms_high_o
);
   localparam int unsigned NB = lanes_of(CNT_W, BYTE_W);

   if (CNT_W % BYTE_W != 0) begin : g_bad_width
      $error("CNT_W must be a whole number of bytes");
   end
   if (NB < 2) begin : g_bad_lanes
      $error("counter needs at least two byte lanes");
   end

   mode_t             mode;
   logic              commit, loaded, is_zero, is_one, step;
   logic [CNT_W-1:0]  load_val, cnt;

   tckcnt_mode u_mode (
      .clk(clk), .rst_n(rst_n), .wr(mode_wr), .din(mode_din), .mode(mode)
   );

   tckcnt_loader #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_load (
      .clk(clk), .rst_n(rst_n), .wr(ld_wr), .wbyte(ld_byte),
      .commit(commit), .load_val(load_val), .loaded(loaded)
   );

   tckcnt_flags #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_flags (
      .cnt(cnt), .is_zero(is_zero), .is_one(is_one)
   );

   // a byte write always wins over a same-cycle pulse
   assign step = tck_fire && mode.cnt_en && loaded && !is_zero && !ld_wr;

   tckcnt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .commit(commit), .load_val(load_val),
      .step(step), .cnt(cnt)
   );

   logic idle_cond;
   assign idle_cond = !loaded || is_zero;

   assign count_o   = cnt;
   assign loaded_o  = loaded;
   assign term_o    = is_zero;
   assign last_o    = is_one;
   assign stall_o   = mode.cnt_en && idle_cond;
   assign irq_o     = mode.irq_en && idle_cond;
   assign ms_high_o = mode.auto_en && loaded && is_one;
endmodule

// File: rtl/tckcnt_chk.sv
module tckcnt_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld_wr,
   input logic             tck_fire,
   input logic             cnt_en,
   input logic [CNT_W-1:0] count_o,
   input logic             loaded_o,
   input logic             stall_o,
   input logic             ms_high_o
);
   // R4
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tck_fire && cnt_en && loaded_o && !ld_wr && count_o != '0)
      |=> (count_o == $past(count_o) - 1'b1));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tck_fire && !ld_wr) |=> $stable(count_o));

   // R5
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_o == '0 && !ld_wr) |=> (count_o == '0));

   // R3
   reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_o && ld_wr) |=> (!loaded_o && $stable(count_o)));

   // R6
   unloaded_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !loaded_o) |-> stall_o);

   // R8
   force_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ms_high_o |-> (count_o == CNT_W'(1) && loaded_o));
endmodule

bind tckcnt_top tckcnt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_wr(ld_wr), .tck_fire(tck_fire),
   .cnt_en(mode.cnt_en), .count_o(count_o), .loaded_o(loaded_o),
   .stall_o(stall_o), .ms_high_o(ms_high_o)
);

// File: tb/tckcnt_top_tb.sv
module tckcnt_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_wr = 1'b0;
   logic [2:0]  mode_din = '0;
   logic        ld_wr = 1'b0;
   logic [7:0]  ld_byte = '0;
   logic        tck_fire = 1'b0;
   logic [31:0] count_o;
   logic        loaded_o, term_o, last_o, stall_o, irq_o, ms_high_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   tckcnt_top dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_din(mode_din),
      .ld_wr(ld_wr), .ld_byte(ld_byte), .tck_fire(tck_fire),
      .count_o(count_o), .loaded_o(loaded_o), .term_o(term_o), .last_o(last_o),
      .stall_o(stall_o), .irq_o(irq_o), .ms_high_o(ms_high_o)
   );

   // behavioural reference
   logic [31:0] m_cnt = '0;
   bit          m_loaded = 1'b0;
   logic [2:0]  m_mode = 3'b001;
   logic [7:0]  m_q[$];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_loaded = 1'b0; m_mode = 3'b001; m_q.delete();
      end else begin
         if (ld_wr) begin
            if (m_q.size() == 0) m_loaded = 1'b0;
            m_q.push_back(ld_byte);
            if (m_q.size() == 4) begin
               m_cnt = {m_q[3], m_q[2], m_q[1], m_q[0]};
               m_q.delete();
               m_loaded = 1'b1;
            end
         end else if (tck_fire && m_mode[0] && m_loaded && m_cnt != 0) begin
            m_cnt = m_cnt - 1;
         end
         if (mode_wr) m_mode = mode_din;
      end
      #1;
      if (rst_n) begin
         chk("R4 count", count_o, m_cnt);
         chk("R2 loaded", {31'b0, loaded_o}, {31'b0, m_loaded});
         chk("R5 term", {31'b0, term_o}, {31'b0, m_cnt == 0});
         chk("R9 last", {31'b0, last_o}, {31'b0, m_cnt == 1});
         chk("R6 stall", {31'b0, stall_o}, {31'b0, m_mode[0] && (!m_loaded || m_cnt == 0)});
         chk("R7 irq", {31'b0, irq_o}, {31'b0, m_mode[2] && (!m_loaded || m_cnt == 0)});
         chk("R8 force", {31'b0, ms_high_o}, {31'b0, m_mode[1] && m_loaded && m_cnt == 1});
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mode_wr = 0; ld_wr = 0; tck_fire = 0;
      end
   endtask

   task automatic put_byte(input logic [7:0] b, input logic fire);
      @(negedge clk);
      mode_wr = 0; ld_wr = 1; ld_byte = b; tck_fire = fire;
   endtask

   task automatic load32(input logic [31:0] v);
      for (int i = 0; i < 4; i++) put_byte(v[i*8 +: 8], 1'b0);
      idle(1);
   endtask

   task automatic set_mode(input logic [2:0] m, input logic fire);
      @(negedge clk);
      mode_wr = 1; mode_din = m; ld_wr = 0; tck_fire = fire;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mode_wr = 0; ld_wr = 0; tck_fire = 1;
      end
      idle(1);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", count_o, 32'h0);
      chk("R1 loaded", {31'b0, loaded_o}, 32'h0);
      chk("R1 stall", {31'b0, stall_o}, 32'h1);
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      chk("R1 force", {31'b0, ms_high_o}, 32'h0);

      // R2 byte order
      load32(32'hA1B2C3D4);
      @(negedge clk);
      chk("R2 value", count_o, 32'hA1B2C3D4);
      chk("R2 loaded", {31'b0, loaded_o}, 32'h1);

      // R3 reload with a same-cycle pulse: write wins
      put_byte(8'h05, 1'b1);
      idle(1);
      chk("R3 held", count_o, 32'hA1B2C3D4);
      chk("R3 cleared", {31'b0, loaded_o}, 32'h0);
      put_byte(8'h00, 1'b0); put_byte(8'h00, 1'b0); put_byte(8'h00, 1'b0);
      idle(1);
      chk("R3 committed", count_o, 32'h5);

      // R11 interrupts and force-high on, then run to zero (R5, R8)
      set_mode(3'b111, 1'b0);
      pulses(4);
      chk("R8 force at one", {31'b0, ms_high_o}, 32'h1);
      chk("R9 last at one", {31'b0, last_o}, 32'h1);
      pulses(6);
      chk("R5 held zero", count_o, 32'h0);
      chk("R7 irq at zero", {31'b0, irq_o}, 32'h1);

      // R11 mode write with same-cycle pulse uses the old enable
      load32(32'h0000_0010);
      set_mode(3'b110, 1'b1);
      idle(1);
      chk("R11 old enable", count_o, 32'hF);
      pulses(3);
      chk("R4 disabled", count_o, 32'hF);
      chk("R7 irq not gated", {31'b0, irq_o}, 32'h0);

      // R10 fifth write starts a new load
      set_mode(3'b001, 1'b0);
      load32(32'h0000_0100);
      put_byte(8'h7E, 1'b0);
      idle(1);
      chk("R10 wrap clears", {31'b0, loaded_o}, 32'h0);
      put_byte(8'h00, 1'b0); put_byte(8'h00, 1'b0); put_byte(8'h00, 1'b0);
      idle(1);
      chk("R10 new value", count_o, 32'h7E);

      // mixed random stimulus against the model
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         mode_wr  = ($urandom_range(0, 15) == 0);
         mode_din = 3'($urandom_range(0, 7)) | 3'b001;
         ld_wr    = ($urandom_range(0, 5) == 0);
         ld_byte  = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom);
         if (ld_wr && $urandom_range(0, 1) == 1) ld_byte = 8'h00;
         tck_fire = ($urandom_range(0, 3) != 0);
      end
      idle(4);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule